// File: doc/BRIEF.md
# Programmable Watchdog Supervisor Timer

This block watches over firmware by counting down a programmable timeout and acting when the count runs out. A single 8-bit configuration register sets three things: the number of ticks to count, which of four tick rates to count, and what happens on expiry. On expiry the block either pulses a reset output for a fixed number of clock cycles or latches an interrupt flag.

Firmware keeps the timer alive in one of two ways. It can write the register again, for example with the same value. It can also toggle a dedicated watchdog input pin, and both rising and falling transitions count. The pin is asynchronous and passes through a synchronizer before it is used. The four tick inputs are one-cycle strobes produced elsewhere at 1/16 s, 1/4 s, 1 s and 4 s.

Top module: `wdt_supervisor`

## Requirements
- R1: While and after the synchronous reset, `rst_out` and `irq_out` are low and the configuration register is 00h, so the timer is disabled.
- R2: Register layout: bit 7 is the action select (1 = reset pulse, 0 = interrupt), bits 6:2 are the tick count N, and bits 1:0 are the rate select. Counting starts at the write, and expiry happens on the N-th selected tick after it.
- R3: Rate select 00, 01, 10 and 11 count `res_tick[0]`, `res_tick[1]`, `res_tick[2]` and `res_tick[3]` respectively; strobes on the other three tick inputs have no effect on the countdown.
- R4: Any register write reloads the countdown with the newly written N.
- R5: Each transition of `wdi_pin`, rising or falling, reloads the countdown with the current N. The transition is taken through two synchronizing flops and acts at the third clock edge after it is sampled.
- R6: In reset mode an expiry drives `rst_out` high for exactly RST_CYC clock cycles, starting the cycle after the expiring tick. Selected ticks are ignored while the pulse is high, and the countdown then continues from a fresh N.
- R7: In interrupt mode an expiry sets `irq_out`, which stays high through any register write except a write of 00h. A write of 00h clears it in the following cycle.
- R8: With N = 0 no expiry occurs, whatever the tick inputs do.
- R9: A register write or a synchronized pin transition in the same cycle as the final selected tick takes precedence and prevents that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| wdi_pin | input | 1 | Asynchronous watchdog kick pin |
| res_tick | input | 4 | One-cycle strobes, one per timeout rate |
| rst_out | output | 1 | Reset pulse on expiry in reset mode |
| irq_out | output | 1 | Sticky interrupt flag on expiry in interrupt mode |

## Verification
The hardest case to reach is a restart arriving in exactly the same cycle as the last tick of a countdown. This matters most for a pin transition, whose effect lags the pin by the synchronizer depth. The bench sets up that race on purpose: it drives the pin change two cycles before the cycle in which it presents the final tick, and it presents a write together with a final tick. A long random phase follows, with sparse ticks, occasional writes and pin toggles. Throughout, a behavioural model compares the outputs on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CFG_W   = 8;
    localparam int MULT_W  = 5;
    localparam int RES_W   = 2;
    localparam int NUM_RES = 1 << RES_W;

    typedef enum logic [RES_W-1:0] {
        RATE_SIXTEENTH = 2'd0,
        RATE_QUARTER   = 2'd1,
        RATE_ONE       = 2'd2,
        RATE_FOUR      = 2'd3
    } wdt_rate_e;

    typedef struct packed {
        logic              to_reset;
        logic [MULT_W-1:0] mult;
        wdt_rate_e         rate;
    } wdt_cfg_t;

    function automatic wdt_cfg_t unpack_cfg(input logic [CFG_W-1:0] raw);
        return wdt_cfg_t'(raw);
    endfunction

    function automatic logic is_clear_code(input logic [CFG_W-1:0] raw);
        return raw == '0;
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic toggled
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign toggled = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux
    import wdt_pkg::*;
(
    input  logic [NUM_RES-1:0] ticks,
    input  wdt_rate_e          rate,
    output logic               tick_sel
);
    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (rate == wdt_rate_e'(i)) tick_sel = ticks[i];
        end
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [MULT_W-1:0] load_val,
    input  logic [MULT_W-1:0] cur_mult,
    input  logic              tick,
    input  logic              to_reset,
    input  logic              irq_clear,
    output logic              pulse_active,
    output logic              irq_flag
);
    localparam int PW = $clog2(RST_CYC + 1);

    logic [MULT_W-1:0] remain_q;
    logic [PW-1:0]     pulse_q;
    logic              irq_q;
    logic              counting;
    logic              expire;

    assign counting = (pulse_q == '0) && (cur_mult != '0) && tick;
    assign expire   = !restart && counting && (remain_q == MULT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (restart) begin
            remain_q <= load_val;
        end else if (expire) begin
            remain_q <= to_reset ? cur_mult : '0;
        end else if (counting && remain_q > MULT_W'(1)) begin
            remain_q <= remain_q - MULT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else if (expire && to_reset) begin
            pulse_q <= PW'(RST_CYC);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (irq_clear) begin
            irq_q <= 1'b0;
        end else if (expire && !to_reset) begin
            irq_q <= 1'b1;
        end
    end

    assign pulse_active = (pulse_q != '0);
    assign irq_flag     = irq_q;

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int RST_CYC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    input  logic               wdi_pin,
    input  logic [NUM_RES-1:0] res_tick,
    output logic               rst_out,
    output logic               irq_out
);
    wdt_cfg_t cfg_q;
    wdt_cfg_t cfg_new;
    logic     kick;
    logic     tick_sel;
    logic     restart;

    assign cfg_new = unpack_cfg(wr_data);

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_new;
    end

    wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (wdi_pin),
        .toggled   (kick)
    );

    wdt_tick_mux u_mux (
        .ticks    (res_tick),
        .rate     (cfg_q.rate),
        .tick_sel (tick_sel)
    );

    assign restart = wr_en || kick;

    wdt_countdown #(.RST_CYC(RST_CYC)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .load_val     (wr_en ? cfg_new.mult : cfg_q.mult),
        .cur_mult     (cfg_q.mult),
        .tick         (tick_sel),
        .to_reset     (cfg_q.to_reset),
        .irq_clear    (wr_en && is_clear_code(wr_data)),
        .pulse_active (rst_out),
        .irq_flag     (irq_out)
    );

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk
    import wdt_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CFG_W-1:0] wr_data,
    input logic             rst_out,
    input logic             irq_out
);
    localparam int LW = $clog2(RST_CYC + 2);

    logic [CFG_W-1:0] shadow_q;
    logic [LW-1:0]    run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            run_q    <= '0;
        end else begin
            if (wr_en) shadow_q <= wr_data;
            if (rst_out && run_q <= LW'(RST_CYC)) run_q <= run_q + LW'(1);
            else if (!rst_out)                   run_q <= '0;
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk) rst |=> !rst_out && !irq_out); // R1
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst) rst_out |-> run_q < LW'(RST_CYC)); // R6
    AST_PULSE_FULL: assert property (@(posedge clk) disable iff (rst) $fell(rst_out) |-> run_q == LW'(RST_CYC)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) irq_out && !(wr_en && wr_data == '0) |=> irq_out); // R7
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst) wr_en && wr_data == '0 |=> !irq_out); // R7
    AST_IRQ_STEER: assert property (@(posedge clk) disable iff (rst) $rose(irq_out) |-> !shadow_q[CFG_W-1]); // R2
    AST_RST_STEER: assert property (@(posedge clk) disable iff (rst) $rose(rst_out) |-> shadow_q[CFG_W-1]); // R2
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst) shadow_q[CFG_W-2:RES_W] == '0 |-> !$rose(rst_out) && !$rose(irq_out)); // R8

endmodule

bind wdt_supervisor wdt_supervisor_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rst_out (rst_out),
    .irq_out (irq_out)
);

// File: tb/wdt_supervisor_tb_top.sv
`timescale 1ns/1ps
module wdt_supervisor_tb_top;
    localparam int RC = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wdi_pin = 1'b0;
    logic [3:0] res_tick = 4'h0;
    logic       rst_out;
    logic       irq_out;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    wdt_supervisor #(.RST_CYC(RC)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wdi_pin(wdi_pin), .res_tick(res_tick),
        .rst_out(rst_out), .irq_out(irq_out)
    );

    // behavioural reference
    int       m_left, m_pulse;
    bit       m_irq;
    bit [7:0] m_cfg;
    bit       pin_hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0; m_pulse = 0; m_irq = 0; m_cfg = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            int  n;
            bit  kick, tk, fire;
            n    = (m_cfg >> 2) & 5'h1f;
            kick = pin_hist[1] != pin_hist[2];
            tk   = res_tick[m_cfg & 3];
            fire = 0;
            if (wr_en) begin
                m_cfg  = wr_data;
                m_left = (wr_data >> 2) & 5'h1f;
                if (wr_data == 0) m_irq = 0;
            end else if (kick) begin
                m_left = n;
            end else if (m_pulse == 0 && n != 0 && tk && m_left != 0) begin
                if (m_left == 1) begin
                    fire = 1;
                    if (m_cfg[7]) m_left = n;
                    else begin m_left = 0; m_irq = 1; end
                end else m_left = m_left - 1;
            end
            if (fire && m_cfg[7]) m_pulse = RC;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            pin_hist.push_front(wdi_pin);
            pin_hist = pin_hist[0:2];
        end
    end

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(rst_out, m_pulse != 0, cur_req, "model rst_out");
            chk(irq_out, m_irq, cur_req, "model irq_out");
        end
    end

    task automatic cyc(input logic [3:0] t, input logic we, input logic [7:0] d);
        @(negedge clk);
        res_tick = t; wr_en = we; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(4'h0, 1'b0, 8'h00);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk(rst_out, 1'b0, "R1", "rst_out in reset");
        chk(irq_out, 1'b0, "R1", "irq_out in reset");
        rst = 1'b0;
        idle(2);
        cyc(4'hf, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b0, "R1", "disabled after reset");

        // reset mode, N=3, rate 01
        cur_req = "R3";
        cyc(4'h0, 1'b1, 8'h8D);
        for (int i = 0; i < 5; i++) cyc(4'b1101, 1'b0, 8'h00);
        idle(1);
        chk(rst_out, 1'b0, "R3", "unselected ticks ignored");
        cur_req = "R2";
        cyc(4'b0010, 1'b0, 8'h00); idle(1);
        cyc(4'b0010, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b0, "R2", "two of three ticks");
        cyc(4'b0010, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b1, "R2", "third tick expires");
        cur_req = "R6";
        cyc(4'b0010, 1'b0, 8'h00); cyc(4'b0010, 1'b0, 8'h00);
        idle(RC - 3);
        chk(rst_out, 1'b1, "R6", "pulse last cycle");
        idle(1);
        chk(rst_out, 1'b0, "R6", "pulse ended");
        cyc(4'b0010, 1'b0, 8'h00); cyc(4'b0010, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b0, "R6", "ticks during pulse ignored, reload");
        cyc(4'b0010, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b1, "R6", "second expiry after reload");
        idle(RC + 2);

        // interrupt mode, N=2, rate 00
        cur_req = "R4";
        cyc(4'h0, 1'b1, 8'h08);
        cyc(4'b0001, 1'b0, 8'h00);
        cyc(4'h0, 1'b1, 8'h08);
        cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(irq_out, 1'b0, "R4", "write reloads");
        cur_req = "R7";
        cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(irq_out, 1'b1, "R7", "irq on expiry");
        chk(rst_out, 1'b0, "R2", "no reset in irq mode");
        cyc(4'h0, 1'b1, 8'h08); idle(1);
        cyc(4'h0, 1'b1, 8'h89); idle(1);
        chk(irq_out, 1'b1, "R7", "nonzero write keeps irq");
        cyc(4'h0, 1'b1, 8'h00); idle(1);
        chk(irq_out, 1'b0, "R7", "00h clears irq");

        // N = 0
        cur_req = "R8";
        cyc(4'h0, 1'b1, 8'h80);
        for (int i = 0; i < 40; i++) cyc(4'hf, 1'b0, 8'h00);
        idle(1);
        chk(rst_out, 1'b0, "R8", "zero count never expires");
        chk(irq_out, 1'b0, "R8", "zero count no irq");

        // pin kicks, reset mode N=2 rate 00
        cur_req = "R5";
        cyc(4'h0, 1'b1, 8'h88);
        cyc(4'b0001, 1'b0, 8'h00); wdi_pin = 1'b1;
        idle(3);
        cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b0, "R5", "rising edge reloads");
        cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b1, "R5", "expiry after rising kick");
        idle(RC + 1);
        cyc(4'b0001, 1'b0, 8'h00); wdi_pin = 1'b0;
        idle(3);
        cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b0, "R5", "falling edge reloads");

        // same-cycle races, count now 1
        cur_req = "R9";
        cyc(4'b0001, 1'b1, 8'h88); idle(1);
        chk(rst_out, 1'b0, "R9", "write beats final tick");
        cyc(4'b0001, 1'b0, 8'h00); wdi_pin = 1'b1;
        idle(1);
        cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b0, "R9", "pin kick beats final tick");
        cyc(4'b0001, 1'b0, 8'h00); cyc(4'b0001, 1'b0, 8'h00); idle(1);
        chk(rst_out, 1'b1, "R9", "expiry after race");
        idle(RC + 2);

        // random mix against the model
        cur_req = "R2";
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] t;
            logic       we;
            logic [7:0] d;
            t  = 4'h0;
            for (int b = 0; b < 4; b++) t[b] = ($urandom_range(0, 5) == 0);
            we = ($urandom_range(0, 150) == 0);
            d  = 8'($urandom_range(0, 255)) & 8'b1000_1111;
            cyc(t, we, d);
            if ($urandom_range(0, 90) == 0) wdi_pin = ~wdi_pin;
        end
        idle(4);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule